// File: doc/BRIEF.md
# Prescaled Interval Timer

This block divides the system clock with a free-running 11-bit prescaler. It uses one prescaler output, chosen by a 3-bit mode value, to advance an 8-bit up-counter. Each time the counter passes from 0xFF back to 0x00, a sticky interrupt request flag is set. The flag stays set until software pulses a clear strobe. The timer therefore gives a periodic interrupt once every 256 selected ticks.

The prescaler runs whenever the block is out of reset and the stop input is low. Writing a new mode does not disturb the prescaler or the count. The whole prescaler value is exported, so that a neighbouring timer can use the same divided clocks. Everything runs in the system clock domain. The chosen prescaler bit is never used as a clock: it is turned into a one-cycle count enable by detecting its rising edge.

Top module: `ivl_timer`

## Requirements
- R1: The prescaler is an 11-bit binary up-counter on `prescTaps`. It advances by one on every clock edge, wrapping from 2047 to 0, while not in reset and with `stopMode` low.
- R2: While `rstN` is low, the prescaler, the timer count and the flag all read 0 and the mode is 0. On the first clock edge after `rstN` rises, the prescaler steps to 1.
- R3: While `stopMode` is high, the prescaler holds its value. No timer tick then occurs, so the count also holds.
- R4: Mode codes 0, 1, 2, 3, 4, 5, 6 and 7 give divide ratios of 2048, 1024, 512, 128, 32, 8, 4 and 2. In steady running, the count advances exactly once per ratio clocks.
- R5: With ratio N, the count increments by one on the clock edge that follows a cycle in which the prescaler has just changed to a value whose remainder modulo N equals N/2.
- R6: A tick at count 0xFF makes the count 0x00 and sets `irqFlag` on the same clock edge.
- R7: `irqFlag` stays set until `flagClr` is high at a clock edge; it then reads 0. When a wrap and `flagClr` meet at the same edge, the flag is set.
- R8: A mode write (`modeWe` high at an edge) leaves the prescaler and the count untouched and takes effect from the next cycle. Switching taps produces no tick unless the new tap itself has a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stopMode | input | 1 | High freezes the prescaler |
| modeWe | input | 1 | Write strobe for the mode value |
| modeWdata | input | 3 | New tap code, 0 to 7 |
| flagClr | input | 1 | Clears the interrupt request flag |
| prescTaps | output | 11 | Current prescaler value, all taps |
| timerCount | output | 8 | Current timer count |
| irqFlag | output | 1 | Sticky overflow interrupt request |

## Verification
The prescaler output changes one edge after the clock it counts. The count changes one edge after the prescaler shows a value whose remainder modulo the ratio is half the ratio, and the flag is set on that same edge when the count wraps. A clear or a mode write takes effect at the edge that samples it. A behavioural model in the bench is stepped at each rising edge with the same inputs the design sees. The design's outputs are compared with the model at every falling edge, half a cycle after the edge at which they are due. Directed checks cover the divide ratios, the freeze under stop, a mode write while the block is stopped, and a clear that coincides with a wrap.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

  localparam int MODE_W = 3;

  // Control-to-datapath strobes
  typedef struct packed {
    logic tick;      // one-cycle count enable
    logic clrFlag;   // flag clear request
  } tmrStrobe_t;

  // Prescaler bit whose rising edge yields the ratio for a mode code
  function automatic int tapBitOf(input int code);
    case (code)
      0:       return 10;  // /2048
      1:       return 9;   // /1024
      2:       return 8;   // /512
      3:       return 6;   // /128
      4:       return 4;   // /32
      5:       return 2;   // /8
      6:       return 1;   // /4
      default: return 0;   // /2
    endcase
  endfunction

endpackage

// File: rtl/ivl_timer_ctrl.sv
module ivl_timer_ctrl
  import ivl_timer_pkg::*;
#(
  parameter int PRESC_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stopMode,
  input  logic               modeWe,
  input  logic [MODE_W-1:0]  modeWdata,
  input  logic               flagClr,
  output logic [PRESC_W-1:0] prescVal,
  output tmrStrobe_t         strobe
);

  localparam int NUM_MODES = 1 << MODE_W;

  logic [PRESC_W-1:0]   presc;
  logic [PRESC_W-1:0]   prescPrev;
  logic [PRESC_W-1:0]   rising;
  logic [MODE_W-1:0]    modeReg;
  logic [NUM_MODES-1:0] modeEdge;

  // Free-running prescaler; frozen only by reset or stop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc     <= '0;
      prescPrev <= '0;
    end else begin
      prescPrev <= presc;
      if (!stopMode) presc <= presc + PRESC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       modeReg <= '0;
    else if (modeWe) modeReg <= modeWdata;
  end

  // Edges of every bit are tracked, so a mode switch cannot fake one
  assign rising = presc & ~prescPrev;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_tap
    localparam int TB = tapBitOf(g);
    assign modeEdge[g] = rising[TB];
  end

  always_comb begin
    strobe.tick    = modeEdge[modeReg];
    strobe.clrFlag = flagClr;
  end

  assign prescVal = presc;

  // R1: prescaler steps by one when running
  p_presc_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    !stopMode |=> presc == $past(presc) + PRESC_W'(1));

  // R3: prescaler frozen in stop mode
  p_stop_freeze_r3: assert property (@(posedge clk) disable iff (!rstN)
    stopMode |=> $stable(presc));

  // R3: no tick while the prescaler is frozen
  p_stop_no_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stopMode && $past(stopMode)) |-> !strobe.tick);

  // R8: mode only changes on a write
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !modeWe |=> $stable(modeReg));

endmodule

// File: rtl/ivl_timer_dp.sv
module ivl_timer_dp
  import ivl_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  output logic [CNT_W-1:0] count,
  output logic             irqFlag
);

  logic wrapNow;

  assign wrapNow = strobe.tick && (count == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else       count <= count + CNT_W'(strobe.tick);
  end

  // Set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               irqFlag <= 1'b0;
    else if (wrapNow)        irqFlag <= 1'b1;
    else if (strobe.clrFlag) irqFlag <= 1'b0;
  end

  // R5: a tick advances the count by one
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick |=> count == $past(count) + CNT_W'(1));

  // R8: without a tick the count holds
  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tick |=> $stable(count));

  // R6: wrap lands on zero with the flag raised
  p_wrap_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && count == '1) |=> (irqFlag && count == '0));

  // R7: flag is sticky without a clear
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !strobe.clrFlag) |=> irqFlag);

  // R7: flag rises only on a wrap
  p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(count) == '1);

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int PRESC_W = 11,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stopMode,
  input  logic               modeWe,
  input  logic [MODE_W-1:0]  modeWdata,
  input  logic               flagClr,
  output logic [PRESC_W-1:0] prescTaps,
  output logic [CNT_W-1:0]   timerCount,
  output logic               irqFlag
);

  tmrStrobe_t strobe;

  ivl_timer_ctrl #(.PRESC_W(PRESC_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .stopMode  (stopMode),
    .modeWe    (modeWe),
    .modeWdata (modeWdata),
    .flagClr   (flagClr),
    .prescVal  (prescTaps),
    .strobe    (strobe)
  );

  ivl_timer_dp #(.CNT_W(CNT_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .count   (timerCount),
    .irqFlag (irqFlag)
  );

endmodule

// File: tb/ivl_timer_tb_top.sv
module ivl_timer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stopMode = 1'b0;
  logic        modeWe = 1'b0;
  logic [2:0]  modeWdata = 3'd0;
  logic        flagClr = 1'b0;
  logic [10:0] prescTaps;
  logic [7:0]  timerCount;
  logic        irqFlag;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;
  bit cmpOn = 1'b0;

  // behavioural reference state
  int mPresc = 0, mPrev = 0, mMode = 0, mCount = 0;
  bit mFlag = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ivl_timer dut_i (
    .clk(clk), .rstN(rstN), .stopMode(stopMode), .modeWe(modeWe),
    .modeWdata(modeWdata), .flagClr(flagClr), .prescTaps(prescTaps),
    .timerCount(timerCount), .irqFlag(irqFlag)
  );

  function automatic int ratioOf(input int m);
    case (m)
      0: return 2048; 1: return 1024; 2: return 512; 3: return 128;
      4: return 32;   5: return 8;    6: return 4;   default: return 2;
    endcase
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // Reference model: stepped on each rising edge with the inputs the design sees
  always @(posedge clk) begin
    if (!rstN) begin
      mPresc = 0; mPrev = 0; mMode = 0; mCount = 0; mFlag = 1'b0;
    end else begin
      int r;
      bit tick;
      r = ratioOf(mMode);
      tick = (mPresc != mPrev) && ((mPresc % r) == r / 2);
      if (tick && mCount == 255) mFlag = 1'b1;
      else if (flagClr) mFlag = 1'b0;
      if (tick) mCount = (mCount + 1) % 256;
      mPrev = mPresc;
      if (!stopMode) mPresc = (mPresc + 1) % 2048;
      if (modeWe) mMode = int'(modeWdata);
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      chk("R1 prescaler vs model", prescTaps, mPresc);
      chk("R5 count vs model", timerCount, mCount);
      chk("R6 flag vs model", irqFlag, mFlag);
    end
  end

  task automatic writeMode(input int m);
    modeWe = 1'b1;
    modeWdata = 3'(m);
    @(negedge clk);
    modeWe = 1'b0;
  endtask

  task automatic measure(input int m);
    logic [7:0] c0;
    int n;
    writeMode(m);
    c0 = timerCount;
    while (timerCount == c0) @(negedge clk);
    c0 = timerCount;
    n = 0;
    while (timerCount == c0) begin
      @(negedge clk);
      n++;
    end
    chk("R4 tick interval", n, ratioOf(m));
  endtask

  initial begin
    logic [10:0] p;
    logic [7:0]  c;
    repeat (3) @(negedge clk);
    chk("R2 reset prescaler", prescTaps, 0);
    chk("R2 reset count", timerCount, 0);
    chk("R2 reset flag", irqFlag, 0);
    cmpOn = 1'b1;
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 first step after release", prescTaps, 1);

    // R6: fastest tap, run to the first wrap
    writeMode(7);
    while (!irqFlag) @(negedge clk);
    chk("R6 count after wrap", timerCount, 0);

    // R7: sticky, then cleared
    repeat (50) @(negedge clk);
    chk("R7 flag sticky", irqFlag, 1);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    chk("R7 flag cleared", irqFlag, 0);

    // R7: clear held across a wrap, set wins
    while (timerCount != 8'hFF) @(negedge clk);
    flagClr = 1'b1;
    while (timerCount != 8'h00) @(negedge clk);
    chk("R7 set wins over clear", irqFlag, 1);
    @(negedge clk);
    chk("R7 clear after wrap", irqFlag, 0);
    flagClr = 1'b0;

    // R3 / R8: freeze, then write mode while frozen
    stopMode = 1'b1;
    @(negedge clk);
    p = prescTaps;
    c = timerCount;
    repeat (30) @(negedge clk);
    chk("R3 prescaler frozen", prescTaps, p);
    chk("R3 count frozen", timerCount, c);
    writeMode(3);
    repeat (2) @(negedge clk);
    chk("R8 prescaler kept on mode write", prescTaps, p);
    chk("R8 count kept on mode write", timerCount, c);
    stopMode = 1'b0;

    // R4: every divide ratio
    for (int m = 7; m >= 0; m--) measure(m);

    repeat (4) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

endmodule